// File: doc/BRIEF.md
# Prescaled Reference-Compare Timer

This block is an up-counting timer driven from the system clock. A clock-source field picks either the clock itself or the clock divided by sixteen. An 8-bit prescaler then divides that stream further. Each prescaler period advances the count by one. When the count reaches a programmed non-zero reference value, the block raises an event flag. It can then restart the count from zero or keep counting past the reference. A level interrupt follows the event flag when the interrupt is enabled.

Software reaches four registers through a simple synchronous port: a mode register, a reference register, the count and an event register. Reads are combinational from the selected register, and writes take effect on the rising clock edge. Any write to the mode or reference register restarts the timer. A write that turns the run bit off returns the whole block to its reset state.

Top module: `ref_tick_timer`

## Requirements
- R1: After reset, mode, reference, count and event registers all read 0 and `irq` is low.
- R2: `addr` selects 0 = mode, 1 = reference, 2 = count, 3 = event. The mode fields are: bit 0 run, bits [2:1] clock source, bit 3 restart-on-reference, bit 4 reference interrupt enable, bits [15:8] prescale. Mode bits [7:5] read as 0, and the event flag reads in bit 0 of the event register.
- R3: With run = 1 and source code 1, the count advances once every (prescale + 1) clock cycles. The first advance lands (prescale + 1) edges after the write edge of the mode or reference register.
- R4: With run = 1 and source code 2, the count advances once every 16 x (prescale + 1) clock cycles, measured from the last mode or reference write.
- R5: With source code 0 or 3, or with run = 0, the count holds its value.
- R6: When the count advances while it equals a non-zero reference, the event flag sets. With restart-on-reference = 1, the count becomes 0 on that advance, so one period lasts reference + 1 advances.
- R7: With restart-on-reference = 0, a match still sets the event flag, but the count carries on to reference + 1. The count wraps from 0xFFFF to 0.
- R8: A reference value of 0 never sets the event flag.
- R9: `irq` is high exactly when the interrupt enable bit and the event flag are both 1. It changes in the same cycle as either of them.
- R10: Writing 1 to event bit 0 clears the flag, and writing 0 to it leaves the flag unchanged. If a clear and a new match fall on the same edge, the flag stays set.
- R11: A write to the count register loads the written value. In that cycle the load replaces any advance, and the dropped advance cannot set the event flag.
- R12: A write to the mode or reference register clears the count and both divider phases. The event flag is kept.
- R13: A mode write that turns the run bit from 1 to 0 returns mode, reference, count and event flag to 0, whatever else the written value holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe for the current cycle |
| addr | input | 2 | Register select |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data of the selected register |
| irq | output | 1 | Level interrupt |

## Verification
Two pairs of functions can land on the same clock edge: a software clear of the event flag and a reference match, and a count load and a count advance. The bench computes the edge of the next match from the reference value and the prescale setting. It then schedules a write-one-to-clear on exactly that edge and expects the flag and `irq` to read 1 afterwards. A count load on a timer that advances every cycle always collides with an advance. The bench judges it by reading back the loaded value, and later the loaded value plus the number of elapsed edges.

// File: rtl/rtimer_pkg.sv
package rtimer_pkg;

  typedef enum logic [1:0] {
    SEL_MODE  = 2'd0,
    SEL_REF   = 2'd1,
    SEL_COUNT = 2'd2,
    SEL_EVENT = 2'd3
  } reg_sel_e;

  typedef enum logic [1:0] {
    SRC_HALT_A = 2'd0,
    SRC_FAST   = 2'd1,
    SRC_SLOW   = 2'd2,
    SRC_HALT_B = 2'd3
  } clk_src_e;

  localparam int MODE_RUN_BIT  = 0;
  localparam int MODE_SRC_LSB  = 1;
  localparam int MODE_WRAP_BIT = 3;
  localparam int MODE_IE_BIT   = 4;
  localparam int MODE_PRE_LSB  = 8;
  localparam int EVT_REF_BIT   = 0;

  // only two of the four source codes let the timer advance
  function automatic logic src_counts(input logic [1:0] code);
    return (code == SRC_FAST) || (code == SRC_SLOW);
  endfunction

endpackage

// File: rtl/rtimer_regs.sv
module rtimer_regs
  import rtimer_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int PRE_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              ref_hit,
  input  logic [DATA_W-1:0] count_q,
  output logic [DATA_W-1:0] mode_q,
  output logic [DATA_W-1:0] ref_q,
  output logic              evt_flag,
  output logic              cfg_restart,
  output logic              cfg_drop,
  output logic              count_load,
  output logic [DATA_W-1:0] rdata,
  output logic              irq
);

  localparam logic [DATA_W-1:0] PRE_FIELD  = DATA_W'(((64'd1 << PRE_W) - 64'd1) << MODE_PRE_LSB);
  localparam logic [DATA_W-1:0] CTRL_FIELD = DATA_W'(5'h1F);
  localparam logic [DATA_W-1:0] MODE_MASK  = PRE_FIELD | CTRL_FIELD;

  reg_sel_e sel;
  logic     wr_mode;
  logic     wr_ref;
  logic     evt_clr;

  function automatic logic flag_next(input logic cur, input logic set, input logic clr);
    // a new match outranks a software clear on the same edge
    return set | (cur & ~clr);
  endfunction

  function automatic logic drops_run(input logic [DATA_W-1:0] old_mode,
                                     input logic [DATA_W-1:0] new_mode);
    return old_mode[MODE_RUN_BIT] & ~new_mode[MODE_RUN_BIT];
  endfunction

  assign sel         = reg_sel_e'(addr);
  assign wr_mode     = wr_en && (sel == SEL_MODE);
  assign wr_ref      = wr_en && (sel == SEL_REF);
  assign count_load  = wr_en && (sel == SEL_COUNT);
  assign evt_clr     = wr_en && (sel == SEL_EVENT) && wdata[EVT_REF_BIT];
  assign cfg_restart = wr_mode || wr_ref;
  assign cfg_drop    = wr_mode && drops_run(mode_q, wdata);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= '0;
      ref_q    <= '0;
      evt_flag <= 1'b0;
    end else if (cfg_drop) begin
      mode_q   <= '0;
      ref_q    <= '0;
      evt_flag <= 1'b0;
    end else begin
      if (wr_mode) mode_q <= wdata & MODE_MASK;
      if (wr_ref)  ref_q  <= wdata;
      evt_flag <= flag_next(evt_flag, ref_hit, evt_clr);
    end
  end

  always_comb begin
    unique case (sel)
      SEL_MODE:  rdata = mode_q;
      SEL_REF:   rdata = ref_q;
      SEL_COUNT: rdata = count_q;
      SEL_EVENT: rdata = DATA_W'(evt_flag);
      default:   rdata = '0;
    endcase
  end

  assign irq = mode_q[MODE_IE_BIT] & evt_flag;

endmodule

// File: rtl/rtimer_tickgen.sv
module rtimer_tickgen
  import rtimer_pkg::*;
#(
  parameter int PRE_W     = 8,
  parameter int SLOW_LOG2 = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [1:0]       src,
  input  logic [PRE_W-1:0] pre_max,
  input  logic             restart,
  output logic             adv
);

  logic             active;
  logic             src_tick;
  logic             pre_done;
  logic [PRE_W-1:0] pre_q;

  function automatic logic at_limit(input logic [PRE_W-1:0] cur, input logic [PRE_W-1:0] lim);
    return cur == lim;
  endfunction

  assign active = run && src_counts(src);

  generate
    if (SLOW_LOG2 > 0) begin : g_slow
      logic [SLOW_LOG2-1:0] slow_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                         slow_q <= '0;
        else if (restart)                   slow_q <= '0;
        else if (active && src == SRC_SLOW) slow_q <= slow_q + 1'b1;
      end
      assign src_tick = active && ((src == SRC_FAST) || (slow_q == '1));
    end else begin : g_noslow
      assign src_tick = active;
    end
  endgenerate

  assign pre_done = at_limit(pre_q, pre_max);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        pre_q <= '0;
    else if (restart)  pre_q <= '0;
    else if (src_tick) pre_q <= pre_done ? '0 : pre_q + 1'b1;
  end

  assign adv = src_tick && pre_done && !restart;

endmodule

// File: rtl/rtimer_counter.sv
module rtimer_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  input  logic             restart,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] ref_val,
  input  logic             wrap_en,
  output logic [CNT_W-1:0] count_q,
  output logic             ref_hit
);

  function automatic logic is_match(input logic [CNT_W-1:0] cnt, input logic [CNT_W-1:0] lim);
    return (lim != '0) && (cnt == lim);
  endfunction

  function automatic logic [CNT_W-1:0] step(input logic [CNT_W-1:0] cnt, input logic wrap_now);
    return wrap_now ? '0 : cnt + 1'b1;
  endfunction

  // an advance that a load replaces does not count as a match
  assign ref_hit = adv && !load && is_match(count_q, ref_val);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       count_q <= '0;
    else if (restart) count_q <= '0;
    else if (load)    count_q <= load_val;
    else if (adv)     count_q <= step(count_q, ref_hit && wrap_en);
  end

endmodule

// File: rtl/ref_tick_timer.sv
module ref_tick_timer
  import rtimer_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int PRE_W     = 8,
  parameter int SLOW_LOG2 = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       addr,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] rdata,
  output logic             irq
);

  logic [CNT_W-1:0] mode_q;
  logic [CNT_W-1:0] ref_q;
  logic [CNT_W-1:0] count_q;
  logic             evt_flag;
  logic             ref_hit;
  logic             adv;
  logic             cfg_restart;
  logic             cfg_drop;
  logic             count_load;

  rtimer_regs #(
    .DATA_W(CNT_W),
    .PRE_W (PRE_W)
  ) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .addr       (addr),
    .wdata      (wdata),
    .ref_hit    (ref_hit),
    .count_q    (count_q),
    .mode_q     (mode_q),
    .ref_q      (ref_q),
    .evt_flag   (evt_flag),
    .cfg_restart(cfg_restart),
    .cfg_drop   (cfg_drop),
    .count_load (count_load),
    .rdata      (rdata),
    .irq        (irq)
  );

  rtimer_tickgen #(
    .PRE_W    (PRE_W),
    .SLOW_LOG2(SLOW_LOG2)
  ) u_tick (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (mode_q[MODE_RUN_BIT]),
    .src    (mode_q[MODE_SRC_LSB +: 2]),
    .pre_max(mode_q[MODE_PRE_LSB +: PRE_W]),
    .restart(cfg_restart),
    .adv    (adv)
  );

  rtimer_counter #(
    .CNT_W(CNT_W)
  ) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .adv     (adv),
    .restart (cfg_restart),
    .load    (count_load),
    .load_val(wdata),
    .ref_val (ref_q),
    .wrap_en (mode_q[MODE_WRAP_BIT]),
    .count_q (count_q),
    .ref_hit (ref_hit)
  );

endmodule

// File: rtl/ref_tick_timer_chk.sv
module ref_tick_timer_chk
  import rtimer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [1:0]       addr,
  input logic [CNT_W-1:0] wdata,
  input logic             irq,
  input logic [CNT_W-1:0] mode_q,
  input logic [CNT_W-1:0] ref_q,
  input logic [CNT_W-1:0] count_q,
  input logic             evt_flag,
  input logic             ref_hit
);

  logic running;
  assign running = mode_q[MODE_RUN_BIT] && src_counts(mode_q[MODE_SRC_LSB +: 2]);

  AST_HIT_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    ref_hit |=> evt_flag); // R6
  AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_hit && mode_q[MODE_WRAP_BIT]) |=> (count_q == '0)); // R6
  AST_FREE_PASSES_REF: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_hit && !mode_q[MODE_WRAP_BIT]) |=> (count_q == $past(count_q) + CNT_W'(1))); // R7
  AST_STOPPED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !wr_en) |=> $stable(count_q)); // R5
  AST_ZERO_REF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_q == '0 && !evt_flag && !wr_en) |=> !evt_flag); // R8
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_q[MODE_IE_BIT] |-> !irq); // R9
  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 2'd3 && wdata[EVT_REF_BIT] && !ref_hit) |=> !evt_flag); // R10
  AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 2'd2) |=> (count_q == $past(wdata))); // R11
  AST_CFG_CLEARS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (addr == 2'd0 || addr == 2'd1)) |=> (count_q == '0)); // R12
  AST_DROP_RESETS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 2'd0 && mode_q[MODE_RUN_BIT] && !wdata[MODE_RUN_BIT])
      |=> (mode_q == '0 && ref_q == '0 && !evt_flag)); // R13

endmodule

bind ref_tick_timer ref_tick_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .wr_en   (wr_en),
  .addr    (addr),
  .wdata   (wdata),
  .irq     (irq),
  .mode_q  (mode_q),
  .ref_q   (ref_q),
  .count_q (count_q),
  .evt_flag(evt_flag),
  .ref_hit (ref_hit)
);

// File: tb/sim_ref_tick_timer.sv
module sim_ref_tick_timer;

  localparam int W       = 16;
  localparam int A_MODE  = 0;
  localparam int A_REF   = 1;
  localparam int A_COUNT = 2;
  localparam int A_EVENT = 3;

  logic         clk   = 1'b0;
  logic         rst_n = 1'b0;
  logic         wr_en = 1'b0;
  logic [1:0]   addr  = 2'd0;
  logic [W-1:0] wdata = '0;
  logic [W-1:0] rdata;
  logic         irq;

  ref_tick_timer #(.CNT_W(W)) u0 (
    .clk  (clk),
    .rst_n(rst_n),
    .wr_en(wr_en),
    .addr (addr),
    .wdata(wdata),
    .rdata(rdata),
    .irq  (irq)
  );

  always #5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int    checks = 0;
  int    errors = 0;
  int    wedge  = 0;
  bit    done   = 0;
  int    q_kind[$];
  int    q_exp[$];
  string q_tag[$];
  event  go;

  // monitor: pops the next expected item and compares with the design
  always @(go) begin
    int    k;
    int    e;
    int    a;
    string t;
    k = q_kind.pop_front();
    e = q_exp.pop_front();
    t = q_tag.pop_front();
    a = (k == 1) ? int'(irq) : int'(rdata);
    checks++;
    if (a != e) begin
      errors++;
      $display("FAIL %s: %s got 0x%0h expected 0x%0h at cycle %0d",
               t, (k == 1) ? "irq" : "rdata", a, e, cyc);
    end
  end

  task automatic at_cyc(input int c);
    while (cyc < c) @(negedge clk);
    if (cyc != c) begin
      checks++;
      errors++;
      $display("FAIL schedule: at cycle %0d, wanted %0d", cyc, c);
    end
  endtask

  task automatic check_reg(input int c, input int a, input int exp, input string tag);
    at_cyc(c);
    addr = 2'(a);
    q_kind.push_back(0);
    q_exp.push_back(exp);
    q_tag.push_back(tag);
    #1 ->go;
    #1;
  endtask

  task automatic check_irq(input int c, input int exp, input string tag);
    at_cyc(c);
    q_kind.push_back(1);
    q_exp.push_back(exp);
    q_tag.push_back(tag);
    #1 ->go;
    #1;
  endtask

  // drive in the low phase of cycle c; the write lands on the next edge
  task automatic write_at(input int c, input int a, input int d);
    at_cyc(c);
    wr_en = 1'b1;
    addr  = 2'(a);
    wdata = W'(d);
    @(posedge clk);
    wedge = c + 1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  initial begin
    int b;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    b = cyc;
    // R1: reset state
    check_reg(b, A_MODE, 0, "R1");
    check_reg(b, A_REF, 0, "R1");
    check_reg(b + 1, A_COUNT, 0, "R1");
    check_reg(b + 1, A_EVENT, 0, "R1");
    check_irq(b + 2, 0, "R1");

    // restart mode, divide by 1, reference 5: period of 6 edges
    write_at(cyc, A_REF, 5);
    write_at(cyc, A_MODE, 16'h001B);
    b = wedge;
    check_reg(b, A_MODE, 16'h001B, "R2");
    check_reg(b, A_REF, 5, "R2");
    check_reg(b + 3, A_COUNT, 3, "R3");
    check_reg(b + 4, A_EVENT, 0, "R6");
    check_reg(b + 6, A_COUNT, 0, "R6");
    check_reg(b + 6, A_EVENT, 1, "R6");
    check_irq(b + 7, 1, "R9");
    check_reg(b + 7, A_COUNT, 1, "R3");
    write_at(b + 8, A_EVENT, 0);
    check_reg(b + 9, A_EVENT, 1, "R10");
    write_at(b + 10, A_EVENT, 1);
    check_reg(b + 11, A_EVENT, 0, "R10");
    check_irq(b + 11, 0, "R9");
    write_at(b + 13, A_EVENT, 1);
    check_reg(b + 14, A_EVENT, 0, "R10");
    // clear lands on the same edge as the third match: the set wins
    write_at(b + 17, A_EVENT, 1);
    check_reg(b + 18, A_EVENT, 1, "R10");
    check_irq(b + 18, 1, "R9");
    // drop interrupt enable; the flag stays and the count restarts
    write_at(b + 19, A_MODE, 16'h000B);
    b = wedge;
    check_reg(b, A_EVENT, 1, "R12");
    check_irq(b, 0, "R9");
    check_reg(b + 1, A_COUNT, 1, "R12");
    write_at(b + 2, A_EVENT, 1);

    // prescaler: divisor 3, then 256
    write_at(cyc, A_REF, 100);
    write_at(cyc, A_MODE, 16'h020B);
    b = wedge;
    check_reg(b + 7, A_COUNT, 2, "R3");
    check_reg(b + 9, A_COUNT, 3, "R3");
    write_at(cyc, A_MODE, 16'hFF0B);
    b = wedge;
    check_reg(b + 255, A_COUNT, 0, "R3");
    check_reg(b + 256, A_COUNT, 1, "R3");

    // slow source: 16 clocks per advance
    write_at(cyc, A_MODE, 16'h000D);
    b = wedge;
    check_reg(b + 15, A_COUNT, 0, "R4");
    check_reg(b + 16, A_COUNT, 1, "R4");
    check_reg(b + 48, A_COUNT, 3, "R4");

    // stopped source codes 0 and 3
    write_at(cyc, A_MODE, 16'h0009);
    b = wedge;
    check_reg(b + 20, A_COUNT, 0, "R5");
    write_at(cyc, A_MODE, 16'h000F);
    b = wedge;
    check_reg(b + 20, A_COUNT, 0, "R5");

    // count load collides with an advance every cycle
    write_at(cyc, A_MODE, 16'h000B);
    b = wedge;
    write_at(b + 4, A_COUNT, 40);
    b = wedge;
    check_reg(b, A_COUNT, 40, "R11");
    check_reg(b + 3, A_COUNT, 43, "R11");
    write_at(b + 4, A_REF, 50);
    b = wedge;
    check_reg(b, A_COUNT, 0, "R12");
    check_reg(b + 2, A_COUNT, 2, "R12");

    // free running past the reference, then wrap at the top
    write_at(cyc, A_REF, 3);
    write_at(cyc, A_MODE, 16'h0003);
    b = wedge;
    check_reg(b + 5, A_COUNT, 5, "R7");
    check_reg(b + 5, A_EVENT, 1, "R7");
    write_at(b + 6, A_COUNT, 16'hFFFE);
    check_reg(b + 9, A_COUNT, 0, "R7");
    write_at(b + 10, A_EVENT, 1);

    // zero reference never matches
    write_at(cyc, A_REF, 0);
    write_at(cyc, A_MODE, 16'h001B);
    b = wedge;
    check_reg(b + 10, A_COUNT, 10, "R8");
    check_reg(b + 10, A_EVENT, 0, "R8");

    // run bit 1 -> 0 wipes every register
    write_at(cyc, A_REF, 5);
    b = wedge;
    check_reg(b + 6, A_EVENT, 1, "R6");
    write_at(b + 7, A_MODE, 16'h0010);
    b = wedge;
    check_reg(b, A_MODE, 0, "R13");
    check_reg(b, A_REF, 0, "R13");
    check_reg(b + 1, A_COUNT, 0, "R13");
    check_reg(b + 1, A_EVENT, 0, "R13");
    check_irq(b + 2, 0, "R13");

    // run stays 0: value is stored masked, count stays put
    write_at(cyc, A_MODE, 16'h00F2);
    b = wedge;
    check_reg(b, A_MODE, 16'h0012, "R2");
    check_reg(b + 10, A_COUNT, 0, "R5");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not end, cycle %0d", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule